// File: doc/BRIEF.md
# UART Transmit Channel with Byte FIFO and Ready Signalling

This block is the transmit half of a serial port. A host pushes bytes into a 16-entry FIFO through a valid/ready write port. A serializer takes bytes from the FIFO one at a time and sends each as an asynchronous character: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts 16 pulses of a baud clock-enable input. When the FIFO holds more bytes, the characters follow one another with no idle time between them. The line rests high when there is nothing to send.

Two status outputs support the host. A level interrupt reports that the FIFO has drained after its last byte moved into the shifter. The interrupt is gated by an enable input. It goes away when the host pulses the status-read strobe, or as soon as a byte is present in the FIFO again. An active-low transmit-ready output drives a DMA handshake. A mode input selects one of two rules for it. With DMA mode off, it is low only while the FIFO is empty. With DMA mode on, it is low while at least one FIFO slot is free.

Back-pressure on the write port is simple. `wr_ready` is high exactly when the FIFO holds fewer than 16 bytes. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. A byte offered while `wr_ready` is low is not stored. The source may hold it or withdraw it, and the FIFO contents do not change.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset `tx_o` is 1, `irq_o` is 0, `wr_ready` is 1 and `txrdy_n_o` is 0.
- R2: Each character is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit. Every bit lasts exactly 16 `baud_tick` pulses. The line stays 1 while no character is being sent.
- R3: Bytes leave in write order. When the FIFO is not empty at the end of a stop bit, the next start bit begins at once, so successive start bits are 160 ticks apart.
- R4: A write is taken only on an edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 exactly when the FIFO holds 16 bytes. The shifter holds one more byte that is not counted in the 16.
- R5: A byte offered while `wr_ready` is 0 is never transmitted, and the bytes already queued are sent unchanged.
- R6: `irq_o` stays 0 while `ien` is 0.
- R7: With `ien` set, `irq_o` rises in the cycle after the edge that moves the last FIFO byte into the shifter.
- R8: A one-cycle `isr_rd` pulse clears `irq_o` from the next cycle, unless the FIFO drains on that same edge.
- R9: A write accepted while `irq_o` is 1 clears `irq_o` from the next cycle.
- R10: With `dma_mode` = 0, `txrdy_n_o` is 0 when the FIFO is empty and 1 when it holds any byte.
- R11: With `dma_mode` = 1, `txrdy_n_o` is 1 only when the FIFO holds 16 bytes, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host offers a byte |
| wr_ready | output | 1 | FIFO can take a byte |
| wr_data | input | 8 | Byte to queue |
| ien | input | 1 | Transmit-empty interrupt enable |
| dma_mode | input | 1 | Selects the transmit-ready rule |
| isr_rd | input | 1 | Status-read strobe, clears the latched interrupt |
| baud_tick | input | 1 | Baud clock enable, 16 per bit |
| tx_o | output | 1 | Serial line |
| irq_o | output | 1 | Transmit-empty interrupt, level |
| txrdy_n_o | output | 1 | Active-low transmit ready |

## Verification
Three input patterns exercise the serializer. The first is one byte written to an idle line. It shows the pop that happens straight from idle, the frame shape, and the moment the interrupt rises. The second is a write that arrives while another character is on the line. It separates clearing the interrupt on a write from clearing it on a status read. The third is a burst of seventeen bytes written with the baud ticks held off, then released. It fills the FIFO to the brim, so a refused extra write and both transmit-ready rules become visible. It also shows whether the characters follow one another without gaps.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [CW-1:0]     level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (level == '0);
  assign full  = (level == CW'(DEPTH));
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int TW    = $clog2(OVS),
  localparam int BW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              avail,
  input  logic [DATA_W-1:0] head,
  output logic              pop,
  output logic              tx,
  output tx_state_e         state
);
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              bit_end;

  assign bit_end = baud_tick && (tcnt == TW'(OVS - 1));
  assign pop     = avail && ((state == ST_IDLE) || (state == ST_STOP && bit_end));

  always_comb begin
    case (state)
      ST_START: tx = 1'b0;
      ST_DATA:  tx = shreg[0];
      default:  tx = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
    end else if (pop) begin
      state <= ST_START;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= head;
    end else if (state != ST_IDLE && baud_tick) begin
      tcnt <= bit_end ? '0 : tcnt + 1'b1;
      if (bit_end) begin
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            shreg <= shreg >> 1;
            bidx  <= bidx + 1'b1;
            if (bidx == BW'(DATA_W - 1)) state <= ST_STOP;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status #(
  parameter bit DMA_FULL_RULE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ien,
  input  logic dma_mode,
  input  logic isr_rd,
  input  logic drained,
  input  logic empty,
  input  logic full,
  output logic irq,
  output logic txrdy_n
);
  logic empty_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       empty_flag <= 1'b0;
    else if (drained) empty_flag <= 1'b1;
    else if (isr_rd)  empty_flag <= 1'b0;
  end

  assign irq = ien && empty && empty_flag;

  generate
    if (DMA_FULL_RULE) begin : g_two_rules
      assign txrdy_n = dma_mode ? full : !empty;
    end else begin : g_empty_rule
      assign txrdy_n = !empty;
    end
  endgenerate
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
  import uart_tx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ien,
  input  logic              dma_mode,
  input  logic              isr_rd,
  input  logic              baud_tick,
  output logic              tx_o,
  output logic              irq_o,
  output logic              txrdy_n_o
);
  logic              push, pop, empty, full, drained;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     level;
  tx_state_e         state;

  assign wr_ready = !full;
  assign push     = wr_valid && wr_ready;
  assign drained  = pop && !push && (level == CW'(1));

  uart_tx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data),
    .pop(pop), .head(head), .empty(empty), .full(full), .level(level)
  );

  uart_tx_serializer #(.DATA_W(DATA_W), .OVS(OVS)) u_ser (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .avail(!empty),
    .head(head), .pop(pop), .tx(tx_o), .state(state)
  );

  uart_tx_status #(.DMA_FULL_RULE(1'b1)) u_stat (
    .clk(clk), .rst_n(rst_n), .ien(ien), .dma_mode(dma_mode),
    .isr_rd(isr_rd), .drained(drained), .empty(empty), .full(full),
    .irq(irq_o), .txrdy_n(txrdy_n_o)
  );
endmodule

// File: rtl/uart_tx_chan_chk.sv
module uart_tx_chan_chk
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic      clk,
  input logic      rst_n,
  input logic      wr_valid,
  input logic      wr_ready,
  input logic      ien,
  input logic      isr_rd,
  input logic      tx_o,
  input logic      irq_o,
  input logic      txrdy_n_o,
  input logic      pop,
  input logic [CW-1:0] level,
  input tx_state_e state
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R4
  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> txrdy_n_o); // R11
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq_o); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !pop) |=> !irq_o); // R8
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !irq_o); // R9
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> tx_o); // R2
endmodule

bind uart_tx_chan uart_tx_chan_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .ien(ien), .isr_rd(isr_rd), .tx_o(tx_o), .irq_o(irq_o),
  .txrdy_n_o(txrdy_n_o), .pop(pop), .level(level), .state(state)
);

// File: tb/tb_uart_tx_chan.sv
module tb_uart_tx_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       ien = 1'b0;
  logic       dma_mode = 1'b0;
  logic       isr_rd = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tx_o, irq_o, txrdy_n_o;

  int unsigned checks = 0, fails = 0, frames = 0, tick_cnt = 0;
  logic [7:0] exp_q [$];
  bit tick_en = 1'b1, b2b_on = 1'b0;
  int unsigned last_start = 0;

  always #2 clk = ~clk;

  uart_tx_chan dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .ien(ien), .dma_mode(dma_mode), .isr_rd(isr_rd),
    .baud_tick(baud_tick), .tx_o(tx_o), .irq_o(irq_o), .txrdy_n_o(txrdy_n_o)
  );

  always @(negedge clk) baud_tick <= tick_en && !baud_tick;
  always @(posedge clk) if (rst_n && baud_tick) tick_cnt <= tick_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // driver: called at a negedge, returns at the negedge after the write edge
  task automatic push(input logic [7:0] b);
    bit acc;
    wr_valid = 1'b1;
    wr_data  = b;
    acc      = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
    if (acc) exp_q.push_back(b);
  endtask

  task automatic wait_tick(input int unsigned t);
    while (tick_cnt < t) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (48) @(negedge clk);
  endtask

  // monitor: decodes frames and compares against the scoreboard queue
  initial begin
    bit prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx_o) begin
        int unsigned s;
        logic [7:0] got;
        logic [7:0] want;
        s = tick_cnt;
        if (b2b_on) chk(s - last_start == 160, "R3 start spacing", s - last_start, 160);
        last_start = s;
        wait_tick(s + 8);
        chk(tx_o == 1'b0, "R2 start bit", tx_o, 0);
        for (int i = 0; i < 8; i++) begin
          wait_tick(s + 24 + 16 * i);
          got[i] = tx_o;
        end
        wait_tick(s + 152);
        chk(tx_o == 1'b1, "R2 stop bit", tx_o, 1);
        frames++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected frame", got, 0);
        end else begin
          want = exp_q.pop_front();
          chk(got == want, "R3 byte order/data", got, want);
        end
      end
      prev = tx_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_o == 1'b1, "R1 tx idle", tx_o, 1);
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    chk(txrdy_n_o == 1'b0, "R1 txrdy_n", txrdy_n_o, 0);

    // interrupt disabled: single byte drains with irq held low
    push(8'h3C);
    @(negedge clk);
    chk(irq_o == 1'b0, "R6 irq masked", irq_o, 0);
    drain();

    // single byte on idle line, then overlapping write
    ien = 1'b1;
    push(8'hA5);
    chk(txrdy_n_o == 1'b1, "R10 byte queued", txrdy_n_o, 1);
    chk(irq_o == 1'b0, "R7 before drain", irq_o, 0);
    @(negedge clk);
    chk(irq_o == 1'b1, "R7 irq after last pop", irq_o, 1);
    chk(txrdy_n_o == 1'b0, "R10 fifo empty", txrdy_n_o, 0);
    push(8'h5A);
    chk(irq_o == 1'b0, "R9 write clears irq", irq_o, 0);
    drain();
    chk(irq_o == 1'b1, "R7 irq after second drain", irq_o, 1);
    isr_rd = 1'b1;
    @(negedge clk);
    isr_rd = 1'b0;
    chk(irq_o == 1'b0, "R8 read clears irq", irq_o, 0);
    @(negedge clk);
    chk(irq_o == 1'b0, "R8 irq stays clear", irq_o, 0);

    // burst with ticks held off, DMA rule
    dma_mode = 1'b1;
    tick_en  = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 17; i++) begin
      push(8'(i * 29) ^ 8'h5B);
      if (i == 0)  chk(txrdy_n_o == 1'b0, "R11 one slot used", txrdy_n_o, 0);
      if (i == 15) chk(txrdy_n_o == 1'b0, "R11 one slot free", txrdy_n_o, 0);
    end
    chk(txrdy_n_o == 1'b1, "R11 fifo full", txrdy_n_o, 1);
    chk(wr_ready == 1'b0, "R4 ready low at 16", wr_ready, 0);
    push(8'hEE);
    chk(wr_ready == 1'b0, "R5 refused write keeps full", wr_ready, 0);
    chk(exp_q.size() == 17, "R4 accepted count", exp_q.size(), 17);
    b2b_on  = 1'b1;
    tick_en = 1'b1;
    begin
      int n = 0;
      while (txrdy_n_o && n < 2000) begin
        @(negedge clk);
        n++;
      end
    end
    chk(txrdy_n_o == 1'b0, "R11 slot freed after pop", txrdy_n_o, 0);
    chk(wr_ready == 1'b1, "R4 ready back", wr_ready, 1);
    drain();
    b2b_on = 1'b0;
    chk(frames == 20, "R5 frame total", frames, 20);
    chk(tx_o == 1'b1, "R2 line idle high", tx_o, 1);
    summary();
  end
endmodule